// File: doc/BRIEF.md
# Dual-Port Mailbox and FIFO Access Controller

This block sits between two independently clocked 36-bit ports and a dual-clock FIFO. Port A and port B each sample a chip select, a direction select, an enable and a mailbox select on their own clock. From these inputs the block decides what each port does. Port A can write the FIFO, post a word into the mailbox going towards B, or collect the word B left for it. Port B can read the FIFO, post a word into the mailbox going towards A, or collect the word A left for it. The FIFO storage and the FIFO's own flags live outside the block. The block only produces the write and read strobes for the FIFO and gates them with the FIFO's not-full and not-empty indications.

Each mailbox is one register with an active-low full flag. The flag is shown in the domain of the port that reads the mailbox. A write drives the flag low. A read by the receiving side releases it. The two clock domains exchange toggle events through synchronizer chains, so the writer does not see that a mailbox has been freed until the release has crossed back to its domain. The data outputs are modelled as a value plus a separate output-enable, so the block needs no tri-state drivers inside a chip.

Top module: `mbx_port_ctrl`

## Requirements
- R1: A port's output enable is high only when its chip select is low (active) and its direction select is low (read). When the enable is low, that port's data output is all zeros.
- R2: When port A's output is enabled, port A's data output shows the mailbox-2 register, whatever the value of the mailbox select.
- R3: When port B's output is enabled, port B's data output shows the FIFO read data if the mailbox select is 0 and the mailbox-1 register if it is 1. The mux choice output b_src_mbx_o equals port B's mailbox select (1 = mailbox).
- R4: fifo_wr_o is high exactly when port A has chip select low, direction 1, enable 1, mailbox select 0 and fifo_not_full_i high. Port A's output enable is low whenever fifo_wr_o is high.
- R5: fifo_rd_o is high exactly when port B has chip select low, direction 0, enable 1, mailbox select 0 and fifo_not_empty_i high.
- R6: Port A with chip select low, direction 1, enable 1 and mailbox select 1 writes mailbox 1. Port B with the same settings writes mailbox 2. A write raises the matching mb*_wr_o strobe. The flag in the reading domain goes low within five reader clock cycles (mbf1_no in B, mbf2_no in A). Port B with direction 1 and mailbox select 0 does nothing.
- R7: A mailbox write is ignored, with no strobe and the register contents kept, while the writer's side still sees that mailbox as full.
- R8: A read of a mailbox whose flag is low happens when chip select is low, direction is 0, enable is 1 and mailbox select is 1. It raises the matching mb*_rd_o strobe, and the flag reads high from the next reader clock edge. Once the release has crossed back, the writer may write again.
- R9: A port with chip select high or enable low raises none of its strobes.
- R10: After an active-low asynchronous reset, both mailbox flags are high and both mailboxes are empty.
- R11: On each port at most one of that port's strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_cs_ni | input | 1 | Port A chip select, active low |
| a_dir_i | input | 1 | Port A direction, 1 = write into block, 0 = read |
| a_en_i | input | 1 | Port A enable |
| a_mbx_i | input | 1 | Port A mailbox select |
| a_data_i | input | 36 | Port A write data |
| a_data_o | output | 36 | Port A read data |
| a_oe_o | output | 1 | Port A output enable |
| b_cs_ni | input | 1 | Port B chip select, active low |
| b_dir_i | input | 1 | Port B direction, 1 = write into block, 0 = read |
| b_en_i | input | 1 | Port B enable |
| b_mbx_i | input | 1 | Port B mailbox select |
| b_data_i | input | 36 | Port B write data |
| b_data_o | output | 36 | Port B read data |
| b_oe_o | output | 1 | Port B output enable |
| b_src_mbx_o | output | 1 | Port B output mux choice, 1 = mailbox 1, 0 = FIFO |
| fifo_not_full_i | input | 1 | FIFO can accept a word (port A domain) |
| fifo_not_empty_i | input | 1 | FIFO holds a word (port B domain) |
| fifo_rdata_i | input | 36 | FIFO output register |
| fifo_wr_o | output | 1 | FIFO write strobe, port A clock |
| fifo_rd_o | output | 1 | FIFO read strobe, port B clock |
| mb1_wr_o | output | 1 | Mailbox 1 write taken, port A clock |
| mb1_rd_o | output | 1 | Mailbox 1 released by read, port B clock |
| mb2_wr_o | output | 1 | Mailbox 2 write taken, port B clock |
| mb2_rd_o | output | 1 | Mailbox 2 released by read, port A clock |
| mbf1_no | output | 1 | Mailbox 1 full flag, active low, port B domain |
| mbf2_no | output | 1 | Mailbox 2 full flag, active low, port A domain |

## Verification
The bench fills mailbox 1 and then writes it again before port B reads it. A design that overwrote a full mailbox would show the second word on port B. It reads a mailbox with the enable low to check that merely viewing the mailbox does not release its flag. It also checks that the flag rises on the reader's very next edge and that the writer is only unblocked after the release has crossed back. The FIFO strobes are driven with the not-full and not-empty inputs low. A design that ignored them would emit strobes into a full or empty FIFO. Port B is given direction 1 with mailbox select 0, where a wrong decode would read or write something. In long random runs on one port at a time, the bench tracks the mailbox state and checks every strobe, output enable and data mux choice against its own model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic cs_n;
    logic dir;
    logic en;
    logic mb;
  } port_ctl_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter bit FIFO_ON_WRITE = 1'b1
) (
  input  port_ctl_t ctl_i,
  input  logic      fifo_ok_i,
  output logic      oe_o,
  output logic      fifo_o,
  output logic      mb_wr_o,
  output logic      mb_rd_o,
  output logic      src_mbx_o
);
  logic act;

  assign act     = !ctl_i.cs_n && ctl_i.en;
  assign oe_o    = !ctl_i.cs_n && !ctl_i.dir;
  assign mb_wr_o = act && ctl_i.dir && ctl_i.mb;
  assign mb_rd_o = act && !ctl_i.dir && ctl_i.mb;

  generate
    if (FIFO_ON_WRITE) begin : g_wr_side
      assign fifo_o    = act && ctl_i.dir && !ctl_i.mb && fifo_ok_i;
      assign src_mbx_o = 1'b1;  // read side only ever sees its mailbox
    end else begin : g_rd_side
      assign fifo_o    = act && !ctl_i.dir && !ctl_i.mb && fifo_ok_i;
      assign src_mbx_o = ctl_i.mb;
    end
  endgenerate
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk_w_i,
  input  logic         clk_r_i,
  input  logic         rst_ni,
  input  logic         wr_req_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_req_i,
  output logic [W-1:0] data_o,
  output logic         flag_n_o,
  output logic         wr_ok_o,
  output logic         rd_ok_o
);
  logic wr_tgl_q, rd_tgl_q, rd_tgl_w, wr_tgl_r;
  logic full_w, full_r;

  // writer domain
  assign full_w  = wr_tgl_q ^ rd_tgl_w;
  assign wr_ok_o = wr_req_i && !full_w;

  always_ff @(posedge clk_w_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_tgl_q <= 1'b0;
      data_o   <= '0;
    end else if (wr_ok_o) begin
      wr_tgl_q <= ~wr_tgl_q;
      data_o   <= wdata_i;
    end
  end

  mbx_sync #(.STAGES(STAGES)) i_sync_rd (
    .clk_i(clk_w_i), .rst_ni(rst_ni), .d_i(rd_tgl_q), .q_o(rd_tgl_w)
  );

  // reader domain
  mbx_sync #(.STAGES(STAGES)) i_sync_wr (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .d_i(wr_tgl_q), .q_o(wr_tgl_r)
  );

  assign full_r   = wr_tgl_r ^ rd_tgl_q;
  assign flag_n_o = ~full_r;
  assign rd_ok_o  = rd_req_i && full_r;

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni)      rd_tgl_q <= 1'b0;
    else if (rd_ok_o) rd_tgl_q <= ~rd_tgl_q;
  end

  a_r6_full_after_wr: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    wr_ok_o |=> full_w);
  a_r7_hold_while_full: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    full_w |=> $stable(data_o));
  a_r8_release: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    rd_ok_o |=> flag_n_o);
endmodule

// File: rtl/mbx_port_ctrl.sv
module mbx_port_ctrl
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              a_cs_ni,
  input  logic              a_dir_i,
  input  logic              a_en_i,
  input  logic              a_mbx_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_oe_o,
  input  logic              b_cs_ni,
  input  logic              b_dir_i,
  input  logic              b_en_i,
  input  logic              b_mbx_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_oe_o,
  output logic              b_src_mbx_o,
  input  logic              fifo_not_full_i,
  input  logic              fifo_not_empty_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic              fifo_wr_o,
  output logic              fifo_rd_o,
  output logic              mb1_wr_o,
  output logic              mb1_rd_o,
  output logic              mb2_wr_o,
  output logic              mb2_rd_o,
  output logic              mbf1_no,
  output logic              mbf2_no
);
  localparam int W = DATA_W;

  port_ctl_t   a_ctl, b_ctl;
  logic        a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd, a_src;
  logic [W-1:0] mb1_q, mb2_q;

  assign a_ctl = '{cs_n: a_cs_ni, dir: a_dir_i, en: a_en_i, mb: a_mbx_i};
  assign b_ctl = '{cs_n: b_cs_ni, dir: b_dir_i, en: b_en_i, mb: b_mbx_i};

  mbx_port_dec #(.FIFO_ON_WRITE(1'b1)) i_dec_a (
    .ctl_i(a_ctl), .fifo_ok_i(fifo_not_full_i), .oe_o(a_oe_o), .fifo_o(fifo_wr_o),
    .mb_wr_o(a_mb_wr), .mb_rd_o(a_mb_rd), .src_mbx_o(a_src)
  );

  mbx_port_dec #(.FIFO_ON_WRITE(1'b0)) i_dec_b (
    .ctl_i(b_ctl), .fifo_ok_i(fifo_not_empty_i), .oe_o(b_oe_o), .fifo_o(fifo_rd_o),
    .mb_wr_o(b_mb_wr), .mb_rd_o(b_mb_rd), .src_mbx_o(b_src_mbx_o)
  );

  // mailbox 1: A -> B
  mbx_chan #(.W(W), .STAGES(SYNC_STAGES)) i_mb1 (
    .clk_w_i(clk_a_i), .clk_r_i(clk_b_i), .rst_ni(rst_ni),
    .wr_req_i(a_mb_wr), .wdata_i(a_data_i), .rd_req_i(b_mb_rd),
    .data_o(mb1_q), .flag_n_o(mbf1_no), .wr_ok_o(mb1_wr_o), .rd_ok_o(mb1_rd_o)
  );

  // mailbox 2: B -> A
  mbx_chan #(.W(W), .STAGES(SYNC_STAGES)) i_mb2 (
    .clk_w_i(clk_b_i), .clk_r_i(clk_a_i), .rst_ni(rst_ni),
    .wr_req_i(b_mb_wr), .wdata_i(b_data_i), .rd_req_i(a_mb_rd),
    .data_o(mb2_q), .flag_n_o(mbf2_no), .wr_ok_o(mb2_wr_o), .rd_ok_o(mb2_rd_o)
  );

  assign a_data_o = (a_oe_o && a_src) ? mb2_q : '0;
  assign b_data_o = !b_oe_o ? '0 : (b_src_mbx_o ? mb1_q : fifo_rdata_i);

  a_r4_wr_not_driving: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    fifo_wr_o |-> !a_oe_o);
  a_r5_rd_from_fifo: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    fifo_rd_o |-> (b_oe_o && !b_src_mbx_o));
  a_r9_idle_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_cs_ni || !a_en_i) |-> !(fifo_wr_o || mb1_wr_o || mb2_rd_o));
  a_r9_idle_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_cs_ni || !b_en_i) |-> !(fifo_rd_o || mb2_wr_o || mb1_rd_o));
  a_r11_one_fn_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    $onehot0({fifo_wr_o, mb1_wr_o, mb2_rd_o}));
  a_r11_one_fn_b: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $onehot0({fifo_rd_o, mb2_wr_o, mb1_rd_o}));
endmodule

// File: tb/test_mbx_port_ctrl.sv
module test_mbx_port_ctrl;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_dir = 1'b0, a_en = 1'b0, a_mb = 1'b0;
  logic b_cs_n = 1'b1, b_dir = 1'b0, b_en = 1'b0, b_mb = 1'b0;
  logic [W-1:0] a_din = '0, b_din = '0, fifo_rdata = '0;
  logic fifo_nf = 1'b1, fifo_ne = 1'b1;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, b_oe, b_src, fifo_wr, fifo_rd;
  logic mb1_wr, mb1_rd, mb2_wr, mb2_rd, mbf1_n, mbf2_n;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  mbx_port_ctrl i_mbx_port_ctrl (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_cs_ni(a_cs_n), .a_dir_i(a_dir), .a_en_i(a_en), .a_mbx_i(a_mb),
    .a_data_i(a_din), .a_data_o(a_dout), .a_oe_o(a_oe),
    .b_cs_ni(b_cs_n), .b_dir_i(b_dir), .b_en_i(b_en), .b_mbx_i(b_mb),
    .b_data_i(b_din), .b_data_o(b_dout), .b_oe_o(b_oe), .b_src_mbx_o(b_src),
    .fifo_not_full_i(fifo_nf), .fifo_not_empty_i(fifo_ne), .fifo_rdata_i(fifo_rdata),
    .fifo_wr_o(fifo_wr), .fifo_rd_o(fifo_rd),
    .mb1_wr_o(mb1_wr), .mb1_rd_o(mb1_rd), .mb2_wr_o(mb2_wr), .mb2_rd_o(mb2_rd),
    .mbf1_no(mbf1_n), .mbf2_no(mbf2_n)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // control nibble: {cs_n, dir, en, mb}
  task automatic a_set(input logic [3:0] c, input logic [W-1:0] d, input logic nf);
    @(posedge clk_a); #1;
    {a_cs_n, a_dir, a_en, a_mb} = c; a_din = d; fifo_nf = nf;
    #3;
  endtask

  task automatic b_set(input logic [3:0] c, input logic [W-1:0] d, input logic ne,
                       input logic [W-1:0] rd);
    @(posedge clk_b); #1;
    {b_cs_n, b_dir, b_en, b_mb} = c; b_din = d; fifo_ne = ne; fifo_rdata = rd;
    #4;
  endtask

  function automatic logic act_f(input logic [3:0] c);
    return !c[3] && c[1];
  endfunction
  function automatic logic oe_f(input logic [3:0] c);
    return !c[3] && !c[2];
  endfunction

  localparam logic [3:0] IDLE = 4'b1000;
  localparam logic [W-1:0] D1 = 36'h1_1111_0001, D2 = 36'h2_2222_0002, D3 = 36'h3_3333_0003;
  localparam logic [W-1:0] E1 = 36'hA_AAAA_000A, E2 = 36'hB_BBBB_000B, E9 = 36'h9_9999_0009;
  localparam logic [W-1:0] FR = 36'hF_0F0F_1234;

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a_full1, m_mbf2, m_mbf1, b_full2;
    logic [W-1:0] m_mb1, m_mb2;
    void'($urandom(32'd2024));

    #33 rst_n = 1'b1;
    a_set(IDLE, '0, 1);
    chk("R10 mbf1 after reset", mbf1_n, 1);
    chk("R10 mbf2 after reset", mbf2_n, 1);
    chk("R1 a_oe deselected", a_oe, 0);
    chk("R1 a_data zero", a_dout, '0);
    chk("R1 b_oe deselected", b_oe, 0);
    chk("R9 a strobes idle", {fifo_wr, mb1_wr, mb2_rd}, 0);

    // mailbox 1 round trip
    a_set(4'b0111, D1, 1);
    chk("R6 mb1 write", mb1_wr, 1);
    chk("R11 no fifo wr with mb", fifo_wr, 0);
    a_set(IDLE, '0, 1);
    repeat (5) @(posedge clk_b); #2;
    chk("R6 mbf1 low", mbf1_n, 0);
    a_set(4'b0111, D2, 1);
    chk("R7 mb1 write ignored", mb1_wr, 0);
    a_set(IDLE, '0, 1);
    b_set(4'b0001, '0, 1, FR);
    chk("R1 b_oe read", b_oe, 1);
    chk("R7 mb1 keeps first word", b_dout, D1);
    chk("R3 b_src mailbox", b_src, 1);
    chk("R9 no release with en low", mb1_rd, 0);
    b_set(4'b0011, '0, 1, FR);
    chk("R8 mb1 read strobe", mb1_rd, 1);
    chk("R9 flag kept before read edge", mbf1_n, 0);
    b_set(IDLE, '0, 1, FR);
    chk("R8 mbf1 released", mbf1_n, 1);
    repeat (5) @(posedge clk_a);
    a_set(4'b0111, D3, 1);
    chk("R8 writer unblocked", mb1_wr, 1);
    a_set(IDLE, '0, 1);
    repeat (5) @(posedge clk_b);
    b_set(4'b0011, '0, 1, FR);
    chk("R6 mb1 new word", b_dout, D3);
    chk("R8 mb1 read again", mb1_rd, 1);
    b_set(IDLE, '0, 1, FR);

    // mailbox 2
    b_set(4'b0111, E1, 1, FR);
    chk("R6 mb2 write", mb2_wr, 1);
    b_set(4'b0110, E9, 1, FR);
    chk("R6 b dir1 mb0 no action", {fifo_rd, mb2_wr, mb1_rd, b_oe}, 0);
    b_set(4'b0111, E9, 1, FR);
    chk("R7 mb2 write ignored", mb2_wr, 0);
    b_set(IDLE, '0, 1, FR);
    repeat (5) @(posedge clk_a);
    a_set(4'b0000, '0, 1);
    chk("R2 a_oe", a_oe, 1);
    chk("R2 a_data mb2", a_dout, E1);
    chk("R6 mbf2 low", mbf2_n, 0);
    a_set(4'b0010, '0, 1);
    chk("R2 a_data mb2 mb0", a_dout, E1);
    chk("R11 read with mb0 no fn", {fifo_wr, mb1_wr, mb2_rd}, 0);
    a_set(4'b0011, '0, 1);
    chk("R8 mb2 read strobe", mb2_rd, 1);
    a_set(IDLE, '0, 1);
    chk("R8 mbf2 released", mbf2_n, 1);

    // FIFO strobes
    a_set(4'b0110, D1, 0);
    chk("R4 no wr when full", fifo_wr, 0);
    a_set(4'b0110, D1, 1);
    chk("R4 fifo write", fifo_wr, 1);
    chk("R4 a_oe off on write", a_oe, 0);
    a_set(4'b1110, D1, 1);
    chk("R9 cs high no write", fifo_wr, 0);
    a_set(4'b0100, D1, 1);
    chk("R9 en low no write", fifo_wr, 0);
    a_set(IDLE, '0, 1);
    b_set(4'b0010, '0, 0, FR);
    chk("R5 no rd when empty", fifo_rd, 0);
    b_set(4'b0010, '0, 1, FR);
    chk("R5 fifo read", fifo_rd, 1);
    chk("R3 b_data fifo", b_dout, FR);
    chk("R3 b_src fifo", b_src, 0);
    b_set(4'b1010, '0, 1, FR);
    chk("R1 b_oe cs high", b_oe, 0);
    chk("R1 b_data zero", b_dout, '0);
    b_set(IDLE, '0, 1, FR);

    // set up known state for random phases
    b_set(4'b0111, E2, 1, FR);
    chk("R6 mb2 refill", mb2_wr, 1);
    b_set(IDLE, '0, 1, FR);
    repeat (6) @(posedge clk_a);
    a_full1 = 0; m_mbf2 = 0; m_mb1 = D3; m_mb2 = E2;

    // random port A, B idle
    for (int i = 0; i < 300; i++) begin
      logic [3:0] c;
      logic [W-1:0] d;
      logic nf, e_wr1, e_rd2;
      c = $urandom_range(15, 0);
      if ($urandom_range(3, 0) != 0) c[3] = 1'b0;
      d = {$urandom_range(15, 0), $urandom()};
      nf = $urandom_range(1, 0);
      a_set(c, d, nf);
      e_wr1 = act_f(c) && c[2] && c[0] && !a_full1;
      e_rd2 = act_f(c) && !c[2] && c[0] && !m_mbf2;
      chk("R1 rnd a_oe", a_oe, oe_f(c));
      chk("R2 rnd a_data", a_dout, oe_f(c) ? m_mb2 : '0);
      chk("R4 rnd fifo_wr", fifo_wr, act_f(c) && c[2] && !c[0] && nf);
      chk("R7 rnd mb1_wr", mb1_wr, e_wr1);
      chk("R8 rnd mb2_rd", mb2_rd, e_rd2);
      chk("R8 rnd mbf2", mbf2_n, !m_mbf2 ? 1'b0 : 1'b1);
      if (e_wr1) begin a_full1 = 1; m_mb1 = d; end
      if (e_rd2) m_mbf2 = 1;
    end
    a_set(IDLE, '0, 1);
    repeat (6) @(posedge clk_b);
    m_mbf1 = !a_full1;
    b_full2 = !m_mbf2;

    // random port B, A idle
    for (int i = 0; i < 300; i++) begin
      logic [3:0] c;
      logic [W-1:0] d, r;
      logic ne, e_wr2, e_rd1;
      c = $urandom_range(15, 0);
      if ($urandom_range(3, 0) != 0) c[3] = 1'b0;
      d = {$urandom_range(15, 0), $urandom()};
      r = {$urandom_range(15, 0), $urandom()};
      ne = $urandom_range(1, 0);
      b_set(c, d, ne, r);
      e_wr2 = act_f(c) && c[2] && c[0] && !b_full2;
      e_rd1 = act_f(c) && !c[2] && c[0] && !m_mbf1;
      chk("R1 rnd b_oe", b_oe, oe_f(c));
      chk("R3 rnd b_data", b_dout, !oe_f(c) ? '0 : (c[0] ? m_mb1 : r));
      chk("R3 rnd b_src", b_src, c[0]);
      chk("R5 rnd fifo_rd", fifo_rd, act_f(c) && !c[2] && !c[0] && ne);
      chk("R7 rnd mb2_wr", mb2_wr, e_wr2);
      chk("R8 rnd mb1_rd", mb1_rd, e_rd1);
      chk("R8 rnd mbf1", mbf1_n, m_mbf1);
      if (e_wr2) b_full2 = 1;
      if (e_rd1) m_mbf1 = 1;
    end
    b_set(IDLE, '0, 1, FR);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule